// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This block carries out the bit-level instructions of a small processor on one byte. It takes an operation code, a byte operand, a bit index and the current carry and zero flags. It returns the byte to write back, a write-enable for that byte, and the next carry and zero flags. Fetching the operand and choosing an addressing mode are done by the surrounding datapath.

The carry flag acts as a one-bit accumulator. A bit can be loaded into it, stored from it, or combined into it with AND, OR or XOR. Every load, store and combining operation also has a variant that uses the complement. Set, clear and invert change the selected bit in place, and test reports the selected bit through the zero flag. All results are registered, so each answer appears one clock after its inputs.

Top module: `bitu_core`

## Requirements
- R1: While reset (active low) is held, and in the first cycle after it, byte_o, wr_o, c_o and z_o are all 0.
- R2: The outputs are registered. Inputs presented before a rising edge appear at the outputs after that edge and not earlier.
- R3: Codes 0 (set), 1 (clear) and 2 (invert) force the selected bit to 1, force it to 0, or flip it. They assert wr_o, and c_o and z_o equal c_i and z_i.
- R4: Whenever a byte is written back, every bit other than the selected one equals the operand bit.
- R5: Code 3 (test) sets z_o to the inverse of the selected bit. It keeps wr_o low and leaves c_o equal to c_i.
- R6: Code 4 (load) sets c_o to the selected bit, and code 5 (inverted load) sets c_o to its complement. Both keep wr_o low, and z_o equals z_i.
- R7: Code 6 (store) writes c_i into the selected bit, and code 7 (inverted store) writes its complement. Both assert wr_o, and both flags are held.
- R8: Codes 8/9 (AND / inverted AND), 10/11 (OR / inverted OR) and 12/13 (XOR / inverted XOR) set c_o to c_i combined with the selected bit. The odd code of each pair uses the complement of the bit. None of them writes back, and z_o is held.
- R9: Only the low three bits of bit_i select the bit; the upper bits are ignored.
- R10: Codes 14 and 15 do nothing. wr_o stays low, both flags are held, and byte_o equals the operand.
- R11: When wr_o is low, byte_o equals the operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Byte operand |
| bit_i | input | 4 | Bit index; only the low three bits are used |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| byte_o | output | 8 | Resulting byte |
| wr_o | output | 1 | Write-back enable for byte_o |
| c_o | output | 1 | Next carry flag |
| z_o | output | 1 | Next zero flag |

## Verification
Store and inverted store are the two cases where reading the carry and writing the byte happen in the same cycle. The new byte depends on c_i, and the flags must still be held. The sweep drives both carry values against every operand pattern and every bit index. Each result is judged on the whole byte, on wr_o and on both flags together, so a design that corrupts a neighbouring bit or disturbs the carry while it writes is caught. The combining codes are swept the same way, and the bench checks that the byte passes through untouched while only the carry moves.

// File: rtl/bitu_pkg.sv
package bitu_pkg;

  typedef enum logic [3:0] {
    BOP_SET  = 4'd0,
    BOP_CLR  = 4'd1,
    BOP_INV  = 4'd2,
    BOP_TST  = 4'd3,
    BOP_LD   = 4'd4,
    BOP_ILD  = 4'd5,
    BOP_ST   = 4'd6,
    BOP_IST  = 4'd7,
    BOP_AND  = 4'd8,
    BOP_IAND = 4'd9,
    BOP_OR   = 4'd10,
    BOP_IOR  = 4'd11,
    BOP_XOR  = 4'd12,
    BOP_IXOR = 4'd13,
    BOP_RSV0 = 4'd14,
    BOP_RSV1 = 4'd15
  } bitu_op_e;

  // True when the operation writes the byte back
  function automatic logic bitu_writes(input bitu_op_e op);
    case (op)
      BOP_SET, BOP_CLR, BOP_INV, BOP_ST, BOP_IST: bitu_writes = 1'b1;
      default:                                   bitu_writes = 1'b0;
    endcase
  endfunction

  // New value of the selected bit for a writing operation
  function automatic logic bitu_bit_next(input bitu_op_e op, input logic old_b,
                                         input logic carry);
    case (op)
      BOP_SET: bitu_bit_next = 1'b1;
      BOP_CLR: bitu_bit_next = 1'b0;
      BOP_INV: bitu_bit_next = ~old_b;
      BOP_ST:  bitu_bit_next = carry;
      BOP_IST: bitu_bit_next = ~carry;
      default: bitu_bit_next = old_b;
    endcase
  endfunction

  // Next carry: the one-bit accumulator
  function automatic logic bitu_carry_next(input bitu_op_e op, input logic sel_b,
                                           input logic carry);
    case (op)
      BOP_LD:   bitu_carry_next = sel_b;
      BOP_ILD:  bitu_carry_next = ~sel_b;
      BOP_AND:  bitu_carry_next = carry & sel_b;
      BOP_IAND: bitu_carry_next = carry & ~sel_b;
      BOP_OR:   bitu_carry_next = carry | sel_b;
      BOP_IOR:  bitu_carry_next = carry | ~sel_b;
      BOP_XOR:  bitu_carry_next = carry ^ sel_b;
      BOP_IXOR: bitu_carry_next = carry ^ ~sel_b;
      default:  bitu_carry_next = carry;
    endcase
  endfunction

  // Next zero flag: only test touches it
  function automatic logic bitu_zero_next(input bitu_op_e op, input logic sel_b,
                                          input logic zero);
    bitu_zero_next = (op == BOP_TST) ? ~sel_b : zero;
  endfunction

endpackage

// File: rtl/bitu_mask.sv
module bitu_mask #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int SEL_W = $clog2(DATA_W);

  logic [SEL_W-1:0] idx_low;
  assign idx_low = idx_i[SEL_W-1:0];

  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign mask_o[g] = (idx_low == SEL_W'(g));
  end
endmodule

// File: rtl/bitu_byte_path.sv
module bitu_byte_path
  import bitu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bitu_op_e          op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              wr_o
);
  assign wr_o = bitu_writes(op_i);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign byte_o[g] = (mask_i[g] && wr_o) ? bitu_bit_next(op_i, opnd_i[g], c_i)
                                           : opnd_i[g];
  end
endmodule

// File: rtl/bitu_flag_path.sv
module bitu_flag_path
  import bitu_pkg::*;
(
  input  bitu_op_e op_i,
  input  logic     sel_bit_i,
  input  logic     c_i,
  input  logic     z_i,
  output logic     c_o,
  output logic     z_o
);
  assign c_o = bitu_carry_next(op_i, sel_bit_i, c_i);
  assign z_o = bitu_zero_next(op_i, sel_bit_i, z_i);
endmodule

// File: rtl/bitu_core.sv
module bitu_core
  import bitu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IDX_W-1:0]  bit_i,
  input  logic              c_i,
  input  logic              z_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              wr_o,
  output logic              c_o,
  output logic              z_o
);
  bitu_op_e          op;
  logic [DATA_W-1:0] hit_mask;
  logic              sel_bit;
  logic [DATA_W-1:0] byte_nx;
  logic              wr_nx;
  logic              c_nx;
  logic              z_nx;

  assign op = bitu_op_e'(op_i);

  bitu_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .idx_i (bit_i),
    .mask_o(hit_mask)
  );

  assign sel_bit = |(opnd_i & hit_mask);

  bitu_byte_path #(.DATA_W(DATA_W)) u_byte (
    .op_i  (op),
    .opnd_i(opnd_i),
    .mask_i(hit_mask),
    .c_i   (c_i),
    .byte_o(byte_nx),
    .wr_o  (wr_nx)
  );

  bitu_flag_path u_flag (
    .op_i     (op),
    .sel_bit_i(sel_bit),
    .c_i      (c_i),
    .z_i      (z_i),
    .c_o      (c_nx),
    .z_o      (z_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_o <= '0;
      wr_o   <= 1'b0;
      c_o    <= 1'b0;
      z_o    <= 1'b0;
    end else begin
      byte_o <= byte_nx;
      wr_o   <= wr_nx;
      c_o    <= c_nx;
      z_o    <= z_nx;
    end
  end
endmodule

// File: rtl/bitu_core_chk.sv
module bitu_core_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic              c_i,
  input logic              z_i,
  input logic [DATA_W-1:0] hit_mask,
  input logic              sel_bit,
  input logic [DATA_W-1:0] byte_o,
  input logic              wr_o,
  input logic              c_o,
  input logic              z_o
);
  AST_WR_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (c_o == $past(c_i)) && (z_o == $past(z_i))); // R3

  AST_ONE_BIT_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(byte_o ^ $past(opnd_i)) <= 1); // R4

  AST_NOWR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !wr_o) |-> byte_o == $past(opnd_i)); // R11

  AST_TEST_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 4'd3) |-> (c_o == $past(c_i)) && !wr_o); // R5

  AST_LOAD_FROM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 4'd4) |-> c_o == $past(sel_bit)); // R6

  AST_WRITE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wr_o) |-> ((byte_o ^ $past(opnd_i)) & ~$past(hit_mask)) == '0); // R4

  AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_mask) && (hit_mask != '0)); // R9
endmodule

bind bitu_core bitu_core_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_i    (op_i),
  .opnd_i  (opnd_i),
  .c_i     (c_i),
  .z_i     (z_i),
  .hit_mask(hit_mask),
  .sel_bit (sel_bit),
  .byte_o  (byte_o),
  .wr_o    (wr_o),
  .c_o     (c_o),
  .z_o     (z_o)
);

// File: tb/bitu_core_test.sv
module bitu_core_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] opnd_i = '0;
  logic [3:0] bit_i = '0;
  logic       c_i = 1'b0;
  logic       z_i = 1'b0;
  logic [7:0] byte_o;
  logic       wr_o, c_o, z_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitu_core uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i), .bit_i(bit_i),
    .c_i(c_i), .z_i(z_i), .byte_o(byte_o), .wr_o(wr_o), .c_o(c_o), .z_o(z_o)
  );

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act byte=%02h wr=%0b c=%0b z=%0b exp byte=%02h wr=%0b c=%0b z=%0b",
               req, act[10:3], act[2], act[1], act[0], exp[10:3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic string tag_of(input int op);
    if (op <= 2) return "R3_R4";
    if (op == 3) return "R5";
    if (op <= 5) return "R6";
    if (op <= 7) return "R7_R4";
    if (op <= 13) return "R8";
    return "R10";
  endfunction

  // Expected packed {byte, wr, c, z}, restated arithmetically
  function automatic logic [10:0] model(input int op, input int opnd, input int bidx,
                                        input int c, input int z);
    int idx, b, wbit, m, nb, wr, nc, nz;
    idx = bidx % 8;
    m = 1 << idx;
    b = (opnd / m) % 2;
    nb = opnd; wr = 0; nc = c; nz = z; wbit = b;
    case (op)
      0: wbit = 1;
      1: wbit = 0;
      2: wbit = 1 - b;
      3: nz = 1 - b;
      4: nc = b;
      5: nc = 1 - b;
      6: wbit = c;
      7: wbit = 1 - c;
      8: nc = c * b;
      9: nc = c * (1 - b);
      10: nc = (c + b > 0) ? 1 : 0;
      11: nc = (c + 1 - b > 0) ? 1 : 0;
      12: nc = (c + b) % 2;
      13: nc = (c + 1 - b) % 2;
      default: ;
    endcase
    if (op <= 2 || op == 6 || op == 7) begin
      wr = 1;
      nb = opnd - b * m + wbit * m;
    end
    return {8'(nb), 1'(wr), 1'(nc), 1'(nz)};
  endfunction

  initial begin
    int pats[8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};
    @(negedge clk);
    check("R1", {byte_o, wr_o, c_o, z_o}, 11'd0);
    op_i = 4'd0; opnd_i = 8'hFF; c_i = 1'b1; z_i = 1'b1;
    @(negedge clk);
    check("R1", {byte_o, wr_o, c_o, z_o}, 11'd0);
    rst_n = 1'b1;
    // first edge after reset release captures the pending inputs
    op_i = 4'd2; opnd_i = 8'h0F; bit_i = 4'd1; c_i = 1'b0; z_i = 1'b1;
    #1;
    check("R2", {byte_o, wr_o, c_o, z_o}, 11'd0);
    @(negedge clk);
    check("R2", {byte_o, wr_o, c_o, z_o}, model(2, 8'h0F, 1, 0, 1));
    // R9: high index bits ignored
    op_i = 4'd0; opnd_i = 8'h00; bit_i = 4'd13; c_i = 1'b0; z_i = 1'b0;
    @(negedge clk);
    check("R9", {byte_o, wr_o, c_o, z_o}, {8'h20, 1'b1, 1'b0, 1'b0});
    // Main sweep
    for (int op = 0; op < 16; op++)
      for (int p = 0; p < 8; p++)
        for (int bi = 0; bi < 16; bi++)
          for (int cz = 0; cz < 4; cz++) begin
            op_i = 4'(op); opnd_i = 8'(pats[p]); bit_i = 4'(bi);
            c_i = cz[1]; z_i = cz[0];
            @(negedge clk);
            check(bi > 7 ? "R9" : tag_of(op), {byte_o, wr_o, c_o, z_o},
                  model(op, pats[p], bi, cz / 2, cz % 2));
            if (!wr_o) check("R11", {byte_o, 3'b000}, {8'(pats[p]), 3'b000});
          end
    // Reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {byte_o, wr_o, c_o, z_o}, 11'd0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule